// File: doc/BRIEF.md
# I2C Clock-Low Timeout Monitor

This block watches an already synchronized SCL line on behalf of an I2C responder. It measures two things: how long SCL has been held low without a break, and how much low time the responder and the controller have each spent extending the clock since the last bus START or STOP. When a limit is exceeded, it sends a single-cycle reset pulse to the serial-interface logic. It also records the cause in a sticky flag, which stays set until the flag-clear input is asserted.

All durations are counted in ticks of about 1 ms. A programmable prescaler divides the system clock down to this tick, so a test can shrink every window by setting a small divisor. The continuous-low limit depends on the speed mode: there is a longer window for 100 kHz and a shorter one for 400 kHz. The limits on cumulative clock extension apply only in 100 kHz mode. Every limit except one applies only while the timeout-enable input is high. The exception is a long-term watchdog of about 2 s of continuous low time, which always runs. The protocol engine drives the responder-hold and controller-hold inputs, and it marks START and STOP conditions with single-cycle strobes.

Top module: `i2c_timeout_mon`

## Requirements
- R1: A tick occurs once every `tickDiv`+1 clock cycles. All duration counters advance only on a tick, so `tickDiv`=0 gives one tick per clock.
- R2: When `toEnable`=1 and `fastMode`=0, SCL must stay low for SLOW_LIM_MS consecutive ticks before the reset pulse fires, and the pulse sets `causeFlags` bit 0.
- R3: When `toEnable`=1 and `fastMode`=1, the same check uses the shorter FAST_LIM_MS window, and the pulse also sets `causeFlags` bit 0.
- R4: The continuous-low count goes back to zero in any cycle where `sclSync` is high. Two low stretches that are each shorter than the window, separated by a high cycle, never fire.
- R5: When `toEnable`=1 and `fastMode`=0, each tick where SCL is low and `respHold`=1 adds to a responder budget. Reaching RESP_LIM_MS fires the reset pulse and sets `causeFlags` bit 1.
- R6: Under the same conditions, each tick where SCL is low and `ctrlHold`=1 adds to a separate controller budget. Reaching CTRL_LIM_MS fires the reset pulse and sets `causeFlags` bit 2.
- R7: Both budgets clear on `busStart` or `busStop`. Nothing is added to them while `fastMode`=1 or `toEnable`=0.
- R8: When SCL stays low for LONG_LIM_MS consecutive ticks, the reset pulse fires and `causeFlags` bit 3 is set. This happens regardless of `toEnable` and `fastMode`.
- R9: `commReset` is high for exactly one cycle, the cycle after the tick on which a limit is reached. Each limit fires at most once per low stretch or per budget period.
- R10: After reset, `commReset` and `causeFlags` are zero. Flags stay set until a cycle with `flagClear`=1. A cause that fires in that same cycle still sets its flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickDiv | input | DIV_W | Clocks per tick minus one |
| sclSync | input | 1 | Synchronized SCL level |
| toEnable | input | 1 | Enables the speed-dependent and budget limits |
| fastMode | input | 1 | 1 = 400 kHz windows, 0 = 100 kHz windows |
| respHold | input | 1 | Responder is extending the clock |
| ctrlHold | input | 1 | Controller is extending the clock |
| busStart | input | 1 | One-cycle START strobe |
| busStop | input | 1 | One-cycle STOP strobe |
| flagClear | input | 1 | Clears the sticky cause flags |
| commReset | output | 1 | One-cycle reset pulse to the serial interface |
| causeFlags | output | 4 | Sticky causes: 0 continuous, 1 responder, 2 controller, 3 long-term |

## Verification
With `tickDiv`=0, a limit of N ticks is reached on the Nth clock edge where SCL is low (or where a hold is counted), and `commReset` is visible right after that edge. The bench counts low cycles from the start of each stretch and samples one time unit after every rising edge, so the expected pulse index is exactly the limit. Flags are checked one sample after the pulse and one sample after `flagClear`. With `tickDiv`=2, the phase of the divider is free, so the bench accepts a pulse anywhere in the three-cycle window that ends at three times the limit.

// File: rtl/i2c_tmo_pkg.sv
package i2c_tmo_pkg;

  localparam int NUM_CAUSE = 4;
  localparam int CAUSE_LOW  = 0;
  localparam int CAUSE_RESP = 1;
  localparam int CAUSE_CTRL = 2;
  localparam int CAUSE_LONG = 3;

  typedef struct packed {
    logic lowInc;
    logic lowClr;
    logic respInc;
    logic ctrlInc;
    logic cumClr;
  } tmoStrobe_t;

endpackage

// File: rtl/i2c_tmo_satcnt.sv
module i2c_tmo_satcnt #(
  parameter int LIM = 10,
  localparam int W = $clog2(LIM + 1)
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt,
  output logic         hit
);

  localparam logic [W-1:0] TOP = W'(LIM);
  localparam logic [W-1:0] PRE = W'(LIM - 1);

  logic canInc;
  assign canInc = inc && (cnt < TOP);
  // hit marks the increment that lands exactly on the limit
  assign hit = canInc && (cnt == PRE) && !clr;

  always_ff @(posedge clk) begin
    if (!rstN)       cnt <= '0;
    else if (clr)    cnt <= '0;
    else if (canInc) cnt <= cnt + 1'b1;
  end

  p_cum_bounded_r5: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= TOP);

  p_cum_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    clr |=> (cnt == '0));

endmodule

// File: rtl/i2c_tmo_datapath.sv
module i2c_tmo_datapath
  import i2c_tmo_pkg::*;
#(
  parameter int DIV_W       = 20,
  parameter int SLOW_LIM_MS = 30,
  parameter int FAST_LIM_MS = 12,
  parameter int RESP_LIM_MS = 25,
  parameter int CTRL_LIM_MS = 10,
  parameter int LONG_LIM_MS = 2000,
  localparam int LOW_W = $clog2(LONG_LIM_MS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] tickDiv,
  input  logic             fastMode,
  input  tmoStrobe_t       strb,
  output logic             tick,
  output logic [LOW_W-1:0] lowCnt,
  output logic             hitShort,
  output logic             hitLong,
  output logic             hitResp,
  output logic             hitCtrl
);

  localparam logic [LOW_W-1:0] LONG_TOP = LOW_W'(LONG_LIM_MS);
  localparam logic [LOW_W-1:0] LONG_PRE = LOW_W'(LONG_LIM_MS - 1);
  localparam logic [LOW_W-1:0] SLOW_PRE = LOW_W'(SLOW_LIM_MS - 1);
  localparam logic [LOW_W-1:0] FAST_PRE = LOW_W'(FAST_LIM_MS - 1);
  localparam int RESP_W = $clog2(RESP_LIM_MS + 1);
  localparam int CTRL_W = $clog2(CTRL_LIM_MS + 1);

  // tick prescaler, free running
  logic [DIV_W-1:0] divCnt;
  assign tick = (divCnt >= tickDiv);

  always_ff @(posedge clk) begin
    if (!rstN)     divCnt <= '0;
    else if (tick) divCnt <= '0;
    else           divCnt <= divCnt + 1'b1;
  end

  // continuous low counter, saturates at the long-term limit
  logic lowStep;
  logic [LOW_W-1:0] shortPre;
  assign lowStep  = strb.lowInc && !strb.lowClr && (lowCnt < LONG_TOP);
  assign shortPre = fastMode ? FAST_PRE : SLOW_PRE;
  assign hitShort = lowStep && (lowCnt == shortPre);
  assign hitLong  = lowStep && (lowCnt == LONG_PRE);

  always_ff @(posedge clk) begin
    if (!rstN)            lowCnt <= '0;
    else if (strb.lowClr) lowCnt <= '0;
    else if (lowStep)     lowCnt <= lowCnt + 1'b1;
  end

  // cumulative extension budgets
  logic [RESP_W-1:0] respCnt;
  logic [CTRL_W-1:0] ctrlCnt;

  i2c_tmo_satcnt #(.LIM(RESP_LIM_MS)) u_respBudget (
    .clk (clk),
    .rstN(rstN),
    .clr (strb.cumClr),
    .inc (strb.respInc),
    .cnt (respCnt),
    .hit (hitResp)
  );

  i2c_tmo_satcnt #(.LIM(CTRL_LIM_MS)) u_ctrlBudget (
    .clk (clk),
    .rstN(rstN),
    .clr (strb.cumClr),
    .inc (strb.ctrlInc),
    .cnt (ctrlCnt),
    .hit (hitCtrl)
  );

  p_tick_spacing_r1: assert property (@(posedge clk) disable iff (!rstN)
    (tick && (tickDiv != '0)) |=> (!tick || !$stable(tickDiv)));

  p_low_bounded_r8: assert property (@(posedge clk) disable iff (!rstN)
    lowCnt <= LONG_TOP);

  p_low_holds_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!tick && !strb.lowClr) |=> $stable(lowCnt));

endmodule

// File: rtl/i2c_tmo_ctrl.sv
module i2c_tmo_ctrl
  import i2c_tmo_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 tick,
  input  logic                 sclSync,
  input  logic                 toEnable,
  input  logic                 fastMode,
  input  logic                 respHold,
  input  logic                 ctrlHold,
  input  logic                 busStart,
  input  logic                 busStop,
  input  logic                 flagClear,
  input  logic                 hitShort,
  input  logic                 hitLong,
  input  logic                 hitResp,
  input  logic                 hitCtrl,
  output tmoStrobe_t           strb,
  output logic                 commReset,
  output logic [NUM_CAUSE-1:0] causeFlags
);

  logic lowTick;
  logic budgetOn;
  logic [NUM_CAUSE-1:0] fire;

  assign lowTick  = tick && !sclSync;
  assign budgetOn = toEnable && !fastMode;

  always_comb begin
    strb         = '0;
    strb.lowClr  = sclSync;
    strb.lowInc  = lowTick;
    strb.cumClr  = busStart || busStop;
    strb.respInc = lowTick && respHold && budgetOn;
    strb.ctrlInc = lowTick && ctrlHold && budgetOn;
  end

  always_comb begin
    fire             = '0;
    fire[CAUSE_LOW]  = hitShort && toEnable;
    fire[CAUSE_RESP] = hitResp;
    fire[CAUSE_CTRL] = hitCtrl;
    fire[CAUSE_LONG] = hitLong;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      commReset  <= 1'b0;
      causeFlags <= '0;
    end else begin
      commReset  <= |fire;
      causeFlags <= (flagClear ? '0 : causeFlags) | fire;
    end
  end

  p_pulse_cause_r9: assert property (@(posedge clk) disable iff (!rstN)
    commReset |-> (causeFlags != '0));

  p_flag_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    flagClear |=> ((causeFlags == '0) || commReset));

  p_resp_mode_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(causeFlags[CAUSE_RESP]) |-> $past(toEnable && !fastMode));

  p_ctrl_mode_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(causeFlags[CAUSE_CTRL]) |-> $past(toEnable && !fastMode));

  p_long_low_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(causeFlags[CAUSE_LONG]) |-> $past(!sclSync));

endmodule

// File: rtl/i2c_timeout_mon.sv
module i2c_timeout_mon
  import i2c_tmo_pkg::*;
#(
  parameter int DIV_W       = 20,
  parameter int SLOW_LIM_MS = 30,
  parameter int FAST_LIM_MS = 12,
  parameter int RESP_LIM_MS = 25,
  parameter int CTRL_LIM_MS = 10,
  parameter int LONG_LIM_MS = 2000,
  localparam int LOW_W = $clog2(LONG_LIM_MS + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [DIV_W-1:0]     tickDiv,
  input  logic                 sclSync,
  input  logic                 toEnable,
  input  logic                 fastMode,
  input  logic                 respHold,
  input  logic                 ctrlHold,
  input  logic                 busStart,
  input  logic                 busStop,
  input  logic                 flagClear,
  output logic                 commReset,
  output logic [NUM_CAUSE-1:0] causeFlags
);

  tmoStrobe_t       strb;
  logic             tick;
  logic [LOW_W-1:0] lowCnt;
  logic             hitShort;
  logic             hitLong;
  logic             hitResp;
  logic             hitCtrl;

  i2c_tmo_datapath #(
    .DIV_W      (DIV_W),
    .SLOW_LIM_MS(SLOW_LIM_MS),
    .FAST_LIM_MS(FAST_LIM_MS),
    .RESP_LIM_MS(RESP_LIM_MS),
    .CTRL_LIM_MS(CTRL_LIM_MS),
    .LONG_LIM_MS(LONG_LIM_MS)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .tickDiv (tickDiv),
    .fastMode(fastMode),
    .strb    (strb),
    .tick    (tick),
    .lowCnt  (lowCnt),
    .hitShort(hitShort),
    .hitLong (hitLong),
    .hitResp (hitResp),
    .hitCtrl (hitCtrl)
  );

  i2c_tmo_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .tick      (tick),
    .sclSync   (sclSync),
    .toEnable  (toEnable),
    .fastMode  (fastMode),
    .respHold  (respHold),
    .ctrlHold  (ctrlHold),
    .busStart  (busStart),
    .busStop   (busStop),
    .flagClear (flagClear),
    .hitShort  (hitShort),
    .hitLong   (hitLong),
    .hitResp   (hitResp),
    .hitCtrl   (hitCtrl),
    .strb      (strb),
    .commReset (commReset),
    .causeFlags(causeFlags)
  );

  p_low_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    sclSync |=> (lowCnt == '0));

endmodule

// File: tb/i2c_timeout_mon_tb.sv
`timescale 1ns/1ps
module i2c_timeout_mon_tb;

  localparam int DIV_W = 4;
  localparam int SLOW  = 6;
  localparam int FAST  = 3;
  localparam int RESP  = 5;
  localparam int CTRL  = 3;
  localparam int LONG  = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [DIV_W-1:0] tickDiv = '0;
  logic sclSync = 1'b1;
  logic toEnable = 1'b0;
  logic fastMode = 1'b0;
  logic respHold = 1'b0;
  logic ctrlHold = 1'b0;
  logic busStart = 1'b0;
  logic busStop = 1'b0;
  logic flagClear = 1'b0;
  logic commReset;
  logic [3:0] causeFlags;

  int total = 0;
  int bad = 0;
  int lowIdx, pulseCnt, firstPulse, lastPulse;

  always #2.5 clk = ~clk;

  i2c_timeout_mon #(
    .DIV_W(DIV_W), .SLOW_LIM_MS(SLOW), .FAST_LIM_MS(FAST),
    .RESP_LIM_MS(RESP), .CTRL_LIM_MS(CTRL), .LONG_LIM_MS(LONG)
  ) u_dut (
    .clk(clk), .rstN(rstN), .tickDiv(tickDiv), .sclSync(sclSync),
    .toEnable(toEnable), .fastMode(fastMode), .respHold(respHold),
    .ctrlHold(ctrlHold), .busStart(busStart), .busStop(busStop),
    .flagClear(flagClear), .commReset(commReset), .causeFlags(causeFlags)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic resetPulseStats();
    lowIdx = 0; pulseCnt = 0; firstPulse = 0; lastPulse = 0;
  endtask

  task automatic notePulse(input int idx);
    if (commReset) begin
      pulseCnt++;
      if (firstPulse == 0) firstPulse = idx;
      lastPulse = idx;
    end
  endtask

  // low for n cycles with the given holds, then one high cycle
  task automatic burst(input int n, input bit rh, input bit ch);
    sclSync = 1'b0; respHold = rh; ctrlHold = ch;
    for (int i = 0; i < n; i++) begin
      step();
      lowIdx++;
      notePulse(lowIdx);
    end
    sclSync = 1'b1; respHold = 1'b0; ctrlHold = 1'b0;
    step();
    notePulse(lowIdx + 1000);
  endtask

  task automatic strobeBus(input bit isStart);
    busStart = isStart; busStop = !isStart;
    step();
    busStart = 1'b0; busStop = 1'b0;
  endtask

  task automatic clearFlags();
    flagClear = 1'b1;
    step();
    flagClear = 1'b0;
    check("R10 flags after clear", int'(causeFlags), 0);
  endtask

  initial begin
    repeat (3) step();
    check("R10 reset pulse", int'(commReset), 0);
    check("R10 reset flags", int'(causeFlags), 0);
    rstN = 1'b1;
    step();

    // sweep over mode, enable and low duration
    for (int f = 0; f < 2; f++) begin
      for (int e = 0; e < 2; e++) begin
        for (int d = 1; d <= LONG + 2; d++) begin
          int s, nExp, firstExp, lastExp, flagExp;
          fastMode = f[0]; toEnable = e[0];
          s = f ? FAST : SLOW;
          nExp = ((e == 1 && d >= s) ? 1 : 0) + ((d >= LONG) ? 1 : 0);
          firstExp = (e == 1 && d >= s) ? s : ((d >= LONG) ? LONG : 0);
          lastExp = (d >= LONG) ? LONG : firstExp;
          flagExp = ((d >= LONG) ? 8 : 0) | ((e == 1 && d >= s) ? 1 : 0);
          resetPulseStats();
          sclSync = 1'b0;
          for (int i = 1; i <= d; i++) begin
            step();
            notePulse(i);
          end
          sclSync = 1'b1;
          for (int j = 1; j <= 3; j++) begin
            step();
            notePulse(d + j);
          end
          check(f ? "R3 R9 pulse count" : "R2 R9 pulse count", pulseCnt, nExp);
          check(f ? "R3 first pulse cycle" : "R2 first pulse cycle", firstPulse, firstExp);
          check("R8 last pulse cycle", lastPulse, lastExp);
          check("R8 R10 sticky flags", int'(causeFlags), flagExp);
          clearFlags();
        end
      end
    end

    // R4: two short stretches split by one high cycle
    fastMode = 1'b0; toEnable = 1'b1;
    resetPulseStats();
    burst(SLOW - 1, 0, 0);
    burst(SLOW - 1, 0, 0);
    check("R4 no pulse across high cycle", pulseCnt, 0);
    check("R4 flags", int'(causeFlags), 0);

    // R5: responder budget in bursts of two
    strobeBus(1);
    resetPulseStats();
    for (int k = 0; k < 4; k++) burst(2, 1, 0);
    check("R5 responder pulse count", pulseCnt, 1);
    check("R5 responder pulse index", firstPulse, RESP);
    check("R5 responder flag bit1", int'(causeFlags), 2);
    clearFlags();

    // R6: controller budget
    strobeBus(1);
    resetPulseStats();
    for (int k = 0; k < 3; k++) burst(2, 0, 1);
    check("R6 controller pulse count", pulseCnt, 1);
    check("R6 controller pulse index", firstPulse, CTRL);
    check("R6 controller flag bit2", int'(causeFlags), 4);
    clearFlags();

    // R5 R6: both holds at once
    strobeBus(0);
    resetPulseStats();
    for (int k = 0; k < 3; k++) burst(2, 1, 1);
    check("R5 R6 both pulse count", pulseCnt, 2);
    check("R6 both first index", firstPulse, CTRL);
    check("R5 both last index", lastPulse, RESP);
    check("R5 R6 both flags", int'(causeFlags), 6);
    clearFlags();

    // R7: STOP and START clear the budgets
    strobeBus(0);
    resetPulseStats();
    burst(2, 1, 1); burst(2, 1, 0);
    strobeBus(0);
    burst(2, 1, 0); burst(2, 1, 0);
    strobeBus(1);
    burst(2, 1, 0); burst(2, 1, 1);
    check("R7 budgets cleared by stop/start", pulseCnt, 0);
    check("R7 flags after cleared budgets", int'(causeFlags), 0);

    // R7: fast mode and disabled do not count
    strobeBus(1);
    fastMode = 1'b1;
    resetPulseStats();
    for (int k = 0; k < 6; k++) burst(2, 1, 1);
    check("R7 fast mode budget ignored", pulseCnt, 0);
    fastMode = 1'b0; toEnable = 1'b0;
    for (int k = 0; k < 6; k++) burst(2, 1, 1);
    check("R7 disabled budget ignored", pulseCnt, 0);
    toEnable = 1'b1;
    burst(2, 1, 1);
    check("R7 nothing carried in while ignored", pulseCnt, 0);
    check("R7 flags while ignored", int'(causeFlags), 0);
    strobeBus(1);

    // R10: clear and new cause in the same cycle, set wins
    resetPulseStats();
    burst(SLOW, 0, 0);
    check("R10 sticky flag held", int'(causeFlags), 1);
    sclSync = 1'b0;
    for (int i = 1; i < SLOW; i++) step();
    flagClear = 1'b1;
    step();
    flagClear = 1'b0;
    check("R10 set wins over clear pulse", int'(commReset), 1);
    check("R10 set wins over clear flag", int'(causeFlags), 1);
    sclSync = 1'b1;
    step();
    clearFlags();

    // R1: prescaler divides by three
    tickDiv = 4'd2;
    step();
    resetPulseStats();
    sclSync = 1'b0;
    for (int i = 1; i <= 3 * LONG + 2; i++) begin
      step();
      notePulse(i);
    end
    sclSync = 1'b1;
    step();
    check("R1 prescaled pulse count", pulseCnt, 2);
    check("R1 prescaled short window", int'(firstPulse >= 3 * SLOW - 2 && firstPulse <= 3 * SLOW), 1);
    check("R1 prescaled long window", int'(lastPulse >= 3 * LONG - 2 && lastPulse <= 3 * LONG), 1);
    check("R1 prescaled flags", int'(causeFlags), 9);
    clearFlags();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(150000 * 5);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule